// File: doc/BRIEF.md
# Streaming Bit-Matrix Transposer

This block turns N serial input lanes into N-bit parallel output words, and the reverse, by transposing each N-by-N bit block as it streams through. Each input lane delivers one bit per clock, so a block takes N clocks to arrive. Each lane's N-bit serial word then leaves on the output bus as one parallel word, one lane per clock, in lane order. Blocks follow one another with no idle cycle: while one block drains, the next one fills the same storage.

Storage is a single N-by-N grid of flip-flops. Each flip-flop has a two-way selector in front of it. For N clocks data moves along the rows; for the next N clocks it moves down the columns. The output is taken from the grid edge that faces away from where data enters, on the axis at right angles to the one that is filling. The default is N = 8.

Top module: `bit_transposer`

## Requirements
- R1: While `rst_n` is low, `p` is all zeros. Asserting `rst_n` low clears `p` at once, without waiting for a clock edge.
- R2: After `rst_n` is released, `p` stays all zeros through the first N-1 rising clock edges.
- R3: After the N-th rising edge, `p` carries the N bits that arrived on lane `s[0]` over edges 1..N. `p[N-1]` holds the bit sampled first and `p[0]` the bit sampled last.
- R4: After edge N+k, for k from 1 to N-1, `p` carries lane `s[k]`'s word from edges 1..N, with the same bit ordering as R3.
- R5: Block b (b ≥ 1) is made of the inputs sampled on edges N(b-1)+1 .. Nb. Its lane-k word is on `p` after edge Nb+k. `p[j]` equals bit k of the input sampled on edge N(b-1)+N-j. This holds for odd-numbered blocks with no gap between them.
- R6: The same ordering as R5 holds for even-numbered blocks, which fill the grid on the other axis.
- R7: The grid's flow direction swaps exactly once every N edges, on the edge that ends a block. The word shown right after each swap is lane 0 of the block that just finished.
- R8: Releasing reset in the middle of a stream restarts the block count, so R2 to R6 apply again from that release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s | input | N | One serial bit per lane per clock |
| p | output | N | Transposed parallel word, one lane per clock |

## Verification
The hardest case to reach from the ports is a block boundary where the grid reverses axis. At that edge the last bit of the filling block and the first word of the draining block must both land correctly. Any mistake in the direction flag, the input-lane mapping or the output selector shows up only there, and only on alternate blocks. The stimulus therefore streams many blocks back to back with no idle cycle, including random data, all-ones and a walking one. A reference model rebuilds every expected word from the recorded input history. A reset in the middle of a block checks that the boundary count restarts.

// File: rtl/xpose_pkg.sv
`timescale 1ns/1ps
package xpose_pkg;
   typedef enum logic {
      FLOW_ROW = 1'b0,   // data moves west to east, drain on east column
      FLOW_COL = 1'b1    // data moves north to south, drain on south row
   } flow_e;
endpackage

// File: rtl/xpose_phase.sv
`timescale 1ns/1ps
module xpose_phase
   import xpose_pkg::*;
#(
   parameter int N  = 8,
   localparam int CW = (N > 2) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output flow_e         flow
);
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flow <= FLOW_ROW;
      end else if (cnt == LAST) begin
         cnt  <= '0;
         flow <= (flow == FLOW_ROW) ? FLOW_COL : FLOW_ROW;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/xpose_cell.sv
`timescale 1ns/1ps
module xpose_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic take_north,
   input  logic from_west,
   input  logic from_north,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= take_north ? from_north : from_west;
   end
endmodule

// File: rtl/xpose_grid.sv
`timescale 1ns/1ps
module xpose_grid
   import xpose_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  flow_e        flow,
   input  logic [N-1:0] lane_in,
   output logic [N-1:0] east_col,
   output logic [N-1:0] south_row
);
   logic [N-1:0] q [N];
   logic         vert;

   assign vert = (flow == FLOW_COL);

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         logic w_src;
         logic n_src;
         // lane k enters row N-1-k (row flow) or column N-1-k (column flow),
         // so lane 0 always reaches the drain edge first
         if (c == 0) begin : g_wedge
            assign w_src = lane_in[N-1-r];
         end else begin : g_winner
            assign w_src = q[r][c-1];
         end
         if (r == 0) begin : g_nedge
            assign n_src = lane_in[N-1-c];
         end else begin : g_ninner
            assign n_src = q[r-1][c];
         end
         xpose_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .take_north (vert),
            .from_west  (w_src),
            .from_north (n_src),
            .q          (q[r][c])
         );
      end
      assign east_col[r]  = q[r][N-1];
      assign south_row[r] = q[N-1][r];
   end
endmodule

// File: rtl/bit_transposer.sv
`timescale 1ns/1ps
module bit_transposer
   import xpose_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] s,
   output logic [N-1:0] p
);
   localparam int CW = (N > 2) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_size
      $error("bit_transposer: N must be at least 2");
   end

   logic [CW-1:0] cnt;
   flow_e         flow;
   logic [N-1:0]  east_col;
   logic [N-1:0]  south_row;

   xpose_phase #(.N(N)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .flow  (flow)
   );

   xpose_grid #(.N(N)) u_grid (
      .clk       (clk),
      .rst_n     (rst_n),
      .flow      (flow),
      .lane_in   (s),
      .east_col  (east_col),
      .south_row (south_row)
   );

   // drain from the edge facing away from the filling axis
   assign p = (flow == FLOW_ROW) ? east_col : south_row;
endmodule

// File: rtl/bit_transposer_chk.sv
`timescale 1ns/1ps
module bit_transposer_chk
   import xpose_pkg::*;
#(
   parameter int N  = 8,
   localparam int CW = (N > 2) ? $clog2(N) : 1,
   localparam int SW = $clog2(N + 1) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  s,
   input logic [N-1:0]  p,
   input logic [CW-1:0] cnt,
   input flow_e         flow
);
   logic [SW-1:0] since;
   logic [N-1:0]  lane0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
         lane0 <= '0;
      end else begin
         if (since < SW'(N)) since <= since + 1'b1;
         lane0 <= {lane0[N-2:0], s[0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) assert_reset_low_R1: assert (p == '0);
   end

   assert_prefix_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since < SW'(N - 1)) |=> (p == '0));

   assert_lane0_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(N - 1)) |=> (p == $past({lane0[N-2:0], s[0]})));

   assert_swap_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(N - 1)) |=> (flow != $past(flow)));

   assert_hold_mid_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != CW'(N - 1)) |=> $stable(flow));
endmodule

bind bit_transposer bit_transposer_chk #(.N(N)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .s     (s),
   .p     (p),
   .cnt   (cnt),
   .flow  (flow)
);

// File: tb/sim_bit_transposer.sv
`timescale 1ns/1ps
module sim_bit_transposer;
   localparam int N = 8;

   logic         clk   = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] s     = '0;
   wire  [N-1:0] p;

   int n_chk = 0;
   int n_bad = 0;
   int e     = 0;               // edges since reset release
   logic [N-1:0] hist [int];    // input sampled on each edge

   always #2.5 clk = ~clk;

   bit_transposer #(.N(N)) u0 (.clk(clk), .rst_n(rst_n), .s(s), .p(p));

   function automatic logic [N-1:0] model(int ee);
      logic [N-1:0] r;
      int b, k;
      r = '0;
      if (ee < N) return r;
      b = ee / N;
      k = ee % N;
      for (int j = 0; j < N; j++) r[j] = hist[N*(b-1) + N - j][k];
      return r;
   endfunction

   task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s edge %0d: p=%b expected %b", req, e, act, exp);
      end
   endtask

   task automatic step(logic [N-1:0] v);
      string tag;
      int b, k;
      s = v;
      @(posedge clk);
      e++;
      hist[e] = v;
      @(negedge clk);
      b = e / N;
      k = e % N;
      if (e < N)                tag = "R2";
      else if (b == 1 && k == 0) tag = "R3";
      else if (b == 1)          tag = "R4";
      else if (k == 0)          tag = "R7";
      else if (b % 2 == 1)      tag = "R5";
      else                      tag = "R6";
      check(tag, p, model(e));
   endtask

   task automatic mid_reset();
      #1 rst_n = 1'b0;
      #0.5 check("R1", p, '0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1", p, '0);
      rst_n = 1'b1;
      e = 0;
      hist.delete();
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      s = '1;                       // inputs are ignored under reset
      repeat (3) @(negedge clk);
      check("R1", p, '0);
      s = '0;
      rst_n = 1'b1;
      e = 0;
      for (int i = 0; i < 5*N; i++) step(N'($urandom));
      for (int i = 0; i < 2*N; i++) step('1);
      for (int i = 0; i < 2*N; i++) step(N'(1) << (i % N));
      for (int i = 0; i < 3*N + 3; i++) step(N'($urandom));
      mid_reset();
      // R8: stream restarts with a fresh block count after the release
      for (int i = 0; i < 6*N; i++) begin
         step(N'($urandom));
         if (e == N) check("R8", p, model(e));
      end
      for (int i = 0; i < N; i++) step('0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule